// File: doc/BRIEF.md
# H-Bridge Motor PWM Channel

This block is a single pulse-width-modulated motor channel that drives the two legs of an H-bridge. A host writes a period, an on-time and a configuration word through a small word-wide register port. A free-running counter turns the period and on-time into a PWM waveform. The configuration then turns that waveform into a pair of leg drive levels for a coast, forward, backward or brake command.

The configuration also offers several options. A locked-antiphase mode lets the PWM level itself choose the direction. During the low part of each cycle the bridge can either brake or coast. The two legs can be exchanged, and each leg can be inverted on its own. The same leg pair goes to an internal bridge output and an external bridge output, and each has its own enable bit. Period and on-time are double-buffered, so a host may change them at any time without causing a truncated or stretched cycle.

Top module: `hbridge_pwm_chan`

## Requirements
- R1: After reset, every register reads 0 and all four leg outputs are low.
- R2: Address 0 holds the period, address 1 the on-time and address 2 the configuration word, and each reads back the last value written to it. Address 3 is a read-only status word: bit 0 is the PWM level, bit 1 is leg A and bit 2 is leg B, both taken after swap and inversion and before the enables. Writes to address 3 are ignored.
- R3: When configuration bit 0 is set, the counter steps from 0 to period-1 and the PWM level is high while the count is below the on-time, so an on-time at or above the period gives a level that is always high. When bit 0 is clear, the PWM level is low and the counter is held at 0.
- R4: While the counter runs, a new period or on-time takes effect only when the counter wraps from period-1 to 0. While the counter is stopped, a new value takes effect on the next clock.
- R5: In PWM-controlled mode (bit 21 = 0), the action field in bits 19:18 selects the drive. Code 00 (coast) drives both legs low and code 11 (brake) drives both legs high.
- R6: With action 01 (forward), the on-phase drives leg A high and leg B low. With action 10 (backward), the on-phase drives leg B high and leg A low.
- R7: In forward and backward, the off-phase follows bit 24: 0 drives both legs high (brake) and 1 drives both legs low (coast).
- R8: In direction-control mode (bit 21 = 1), leg A follows the PWM level, leg B is its complement and the action field is ignored.
- R9: Bit 23 exchanges leg A and leg B.
- R10: Bit 25 inverts leg A and bit 26 inverts leg B. Inversion is applied after the swap.
- R11: Bit 16 enables the internal leg pair and bit 17 enables the external leg pair. A disabled pair is held low whatever the inversion setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| int_leg_a | output | 1 | Internal bridge, leg A |
| int_leg_b | output | 1 | Internal bridge, leg B |
| ext_leg_a | output | 1 | External bridge, leg A |
| ext_leg_b | output | 1 | External bridge, leg B |

## Verification
The bench rewrites the on-time in the middle of a running cycle, just after the waveform rises. An unbuffered design would show the new duty within that same cycle, and a design that never loads the buffer would keep the old duty afterwards. Duty is counted over one full period with the off-phase set to brake and to coast, and with the legs swapped, single-inverted and double-inverted. A design that inverts before swapping, or that ties the dwell choice to the wrong level, shows the wrong number of high cycles on one leg. Further checks cover an on-time larger than the period, a stopped counter that still holds the brake dwell, the antiphase legs in direction mode, and the output pair whose enable is off, which must stay low.

// File: rtl/hbridge_pwm_chan.sv
module hbridge_pwm_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          int_leg_a,
  output logic          int_leg_b,
  output logic          ext_leg_a,
  output logic          ext_leg_b
);
  localparam int B_RUN   = 0;
  localparam int B_IEN   = 16;
  localparam int B_XEN   = 17;
  localparam int B_ACT   = 18;
  localparam int B_DIR   = 21;
  localparam int B_SWAP  = 23;
  localparam int B_DWELL = 24;
  localparam int B_INVA  = 25;
  localparam int B_INVB  = 26;

  logic [DW-1:0] per_pend, on_pend, cfg, per_act, on_act, cnt;
  logic run, wrap, pwm;
  logic raw_a, raw_b, sw_a, sw_b, leg_a, leg_b;
  logic [1:0] act;

  assign run  = cfg[B_RUN];
  assign act  = cfg[B_ACT +: 2];
  assign wrap = !run || (per_act == '0) || (cnt == per_act - 1'b1);
  assign pwm  = run && (cnt < on_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_pend <= '0;
      on_pend  <= '0;
      cfg      <= '0;
      per_act  <= '0;
      on_act   <= '0;
      cnt      <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          2'd0: per_pend <= reg_wdata;
          2'd1: on_pend  <= reg_wdata;
          2'd2: cfg      <= reg_wdata;
          default: ;
        endcase
      end
      if (wrap) begin
        per_act <= per_pend;
        on_act  <= on_pend;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    raw_a = 1'b0;
    raw_b = 1'b0;
    if (cfg[B_DIR]) begin
      raw_a = pwm;
      raw_b = !pwm;
    end else begin
      case (act)
        2'b01: begin
          raw_a = pwm ? 1'b1 : !cfg[B_DWELL];
          raw_b = pwm ? 1'b0 : !cfg[B_DWELL];
        end
        2'b10: begin
          raw_a = pwm ? 1'b0 : !cfg[B_DWELL];
          raw_b = pwm ? 1'b1 : !cfg[B_DWELL];
        end
        2'b11: begin
          raw_a = 1'b1;
          raw_b = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sw_a  = cfg[B_SWAP] ? raw_b : raw_a;
  assign sw_b  = cfg[B_SWAP] ? raw_a : raw_b;
  assign leg_a = sw_a ^ cfg[B_INVA];
  assign leg_b = sw_b ^ cfg[B_INVB];

  assign int_leg_a = leg_a & cfg[B_IEN];
  assign int_leg_b = leg_b & cfg[B_IEN];
  assign ext_leg_a = leg_a & cfg[B_XEN];
  assign ext_leg_b = leg_b & cfg[B_XEN];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = per_pend;
      2'd1:    reg_rdata = on_pend;
      2'd2:    reg_rdata = cfg;
      default: reg_rdata = {{(DW-3){1'b0}}, leg_b, leg_a, pwm};
    endcase
  end

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act != '0) |-> (cnt < per_act));

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(per_act) && $stable(on_act)));

  p_brake_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[B_DIR] && act == 2'b11 && !cfg[B_INVA] && !cfg[B_INVB] && cfg[B_IEN])
      |-> (int_leg_a && int_leg_b));

  p_idle_dwell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cfg[B_DIR] && act == 2'b01 && !cfg[B_DWELL] && !cfg[B_INVA]
      && !cfg[B_INVB] && cfg[B_IEN]) |-> (int_leg_a && int_leg_b));

  p_antiphase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[B_DIR] && !cfg[B_INVA] && !cfg[B_INVB] && cfg[B_IEN])
      |-> (int_leg_a != int_leg_b));
endmodule

// File: tb/sim_hbridge_pwm_chan.sv
module sim_hbridge_pwm_chan;
  localparam int DW = 32;
  localparam logic [31:0] EN = 32'h1, IE = 32'h1 << 16, XE = 32'h1 << 17;
  localparam logic [31:0] FWD = 32'h1 << 18, BWD = 32'h2 << 18, BRK = 32'h3 << 18;
  localparam logic [31:0] DIR = 32'h1 << 21, SWP = 32'h1 << 23, CST = 32'h1 << 24;
  localparam logic [31:0] INVA = 32'h1 << 25, INVB = 32'h1 << 26;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic int_leg_a, int_leg_b, ext_leg_a, ext_leg_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hbridge_pwm_chan #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_leg_a(int_leg_a), .int_leg_b(int_leg_b),
    .ext_leg_a(ext_leg_a), .ext_leg_b(ext_leg_b));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic count(input int n, output int ca, output int cb, output int xa, output int xb);
    ca = 0; cb = 0; xa = 0; xb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int_leg_a; cb += int_leg_b; xa += ext_leg_a; xb += ext_leg_b;
    end
  endtask

  task automatic setup(input logic [31:0] c);
    wr(2'd2, c);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 legs", {int_leg_a, int_leg_b, ext_leg_a, ext_leg_b}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 regs", d, 0);
    end
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd0, 32'd10); wr(2'd1, 32'd3); wr(2'd2, IE | FWD);
    rd(2'd0, d); check("R2 period", d, 10);
    rd(2'd1, d); check("R2 ontime", d, 3);
    rd(2'd2, d); check("R2 cfg", d, IE | FWD);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); check("R2 status stopped brake dwell", d, 6);
    rd(2'd0, d); check("R2 period after status write", d, 10);
    check("R7 idle brake dwell", {int_leg_a, int_leg_b}, 3);
    wr(2'd2, IE | FWD | CST);
    check("R3 idle coast dwell", {int_leg_a, int_leg_b}, 0);
  endtask

  task automatic t_duty;
    int ca, cb, xa, xb;
    setup(EN | IE | FWD | CST);
    count(10, ca, cb, xa, xb);
    check("R6 fwd leg A duty", ca, 3);
    check("R6 fwd leg B", cb, 0);
    check("R11 ext off", xa + xb, 0);
    count(40, ca, cb, xa, xb);
    check("R3 duty over 4 periods", ca, 12);
    setup(EN | IE | BWD | CST);
    count(10, ca, cb, xa, xb);
    check("R6 bwd leg B duty", cb, 3);
    check("R6 bwd leg A", ca, 0);
    setup(EN | IE | FWD);
    count(10, ca, cb, xa, xb);
    check("R7 brake dwell leg A", ca, 10);
    check("R7 brake dwell leg B", cb, 7);
  endtask

  task automatic t_actions;
    int ca, cb, xa, xb;
    setup(EN | IE | XE);
    count(10, ca, cb, xa, xb);
    check("R5 coast", ca + cb + xa + xb, 0);
    setup(EN | IE | XE | BRK);
    count(10, ca, cb, xa, xb);
    check("R5 brake", ca + cb + xa + xb, 40);
  endtask

  task automatic t_dir;
    int ca, cb, xa, xb, mism;
    setup(EN | XE | DIR | BRK);
    mism = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ext_leg_a == ext_leg_b) mism++;
    end
    check("R8 antiphase", mism, 0);
    count(10, ca, cb, xa, xb);
    check("R8 leg A duty", xa, 3);
    check("R8 leg B duty", xb, 7);
    check("R11 int off", ca + cb, 0);
  endtask

  task automatic t_swap_inv;
    int ca, cb, xa, xb;
    setup(EN | IE | FWD | CST | SWP);
    count(10, ca, cb, xa, xb);
    check("R9 swapped B", cb, 3);
    check("R9 swapped A", ca, 0);
    setup(EN | IE | FWD | CST | SWP | INVA);
    count(10, ca, cb, xa, xb);
    check("R10 inv A after swap", ca, 10);
    check("R10 B untouched", cb, 3);
    setup(EN | IE | FWD | CST | SWP | INVA | INVB);
    count(10, ca, cb, xa, xb);
    check("R10 inv B", cb, 7);
    check("R11 ext gated despite invert", xa + xb, 0);
  endtask

  task automatic t_shadow;
    int ca, cb, xa, xb;
    logic prev;
    setup(EN | IE | FWD | CST);
    prev = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int_leg_a && !prev) break;
      prev = int_leg_a;
    end
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd7;
    @(negedge clk);
    reg_wr = 1'b0;
    ca = int_leg_a;
    count(8, xa, cb, xb, xb);
    ca += xa;
    check("R4 old duty kept to wrap", ca, 2);
    count(10, ca, cb, xa, xb);
    check("R4 new duty after wrap", ca, 7);
    wr(2'd1, 32'd3);
    repeat (12) @(negedge clk);
    wr(2'd2, IE | FWD | CST);
    wr(2'd0, 32'd4); wr(2'd1, 32'd9);
    wr(2'd2, EN | IE | FWD | CST);
    count(10, ca, cb, xa, xb);
    check("R3 ontime above period", ca, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_duty();
    t_actions();
    t_dir();
    t_swap_inv();
    t_shadow();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule